// File: doc/BRIEF.md
# Bandwidth-Accounting Memory Arbiter

This block decides which requester may issue the next burst on a shared DDR port. One DMA engine competes with several CPUs, and the port carries a single burst at a time. A running CPU bandwidth account governs the contest between the DMA and the CPUs. Each CPU burst charges the account. While no CPU burst is in progress, the account decays by a programmable step. When the account sits above a programmable limit, the DMA wins. Otherwise the CPUs go first, and the DMA is served only when no CPU is asking.

Among the CPUs, every requester falls into one of four classes, formed from its priority tag and its budget input. The lowest-numbered class that has a requester wins. Inside that class, the CPU that was granted least recently wins. The charge per CPU burst is either a fixed programmed amount or, in dynamic mode, the cycle count the memory side reports when the burst ends. Command sequencing and the data path belong to other blocks.

Top module: `bw_mem_arbiter`

## Requirements
- R1: At most one grant is asserted at a time. A request seen on a cycle with no grant outstanding asserts its grant from the next cycle. The grant holds until the cycle in which `burst_done_i` is sampled high and drops on the following cycle. The next grant may assert one cycle after that.
- R2: With `cfg_dyn_en_i` low, each completed CPU burst adds `cfg_ratio_i` to the account. A DMA burst adds nothing.
- R3: With `cfg_dyn_en_i` high, each completed CPU burst adds `burst_cycles_i`, sampled on the burst-done cycle, and `cfg_ratio_i` is ignored.
- R4: On every cycle in which no CPU burst is in progress, the account drops by `cfg_decr_i`. It stops at zero and never wraps.
- R5: The account never exceeds `cfg_clip_i`. A charge that would pass the clip leaves the account at the clip.
- R6: When the account is strictly above `cfg_limit_i`, a requesting DMA is granted ahead of all CPUs. When the account is at or below the limit, a requesting CPU is granted ahead of the DMA.
- R7: A DMA request is granted whenever no CPU requests, whatever the account value.
- R8: CPU classes are ranked as follows. Class 0 is `cpu_hi_i`=1 with `cpu_in_budget_i`=1. Class 1 is hi=0 with budget=1. Class 2 is hi=1 with budget=0. Class 3 is hi=0 with budget=0. The lowest class holding a requester is served.
- R9: Within a class, the least recently granted requesting CPU wins. After reset, the order is lowest index first. The recency order changes only when a CPU grant is issued.
- R10: With no request present, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ratio_i | input | ACC_W | Static charge per CPU burst |
| cfg_decr_i | input | ACC_W | Decay step per non-CPU cycle |
| cfg_limit_i | input | ACC_W | Account threshold above which DMA wins |
| cfg_clip_i | input | ACC_W | Account saturation ceiling |
| cfg_dyn_en_i | input | 1 | Charge measured burst cycles instead of ratio |
| dma_req_i | input | 1 | DMA request |
| dma_gnt_o | output | 1 | DMA grant, held for the burst |
| cpu_req_i | input | N_CPU | Per-CPU requests |
| cpu_hi_i | input | N_CPU | Per-CPU priority tag, 1 = high |
| cpu_in_budget_i | input | N_CPU | Per-CPU budget status, 1 = in budget |
| cpu_gnt_o | output | N_CPU | Per-CPU grants, held for the burst |
| burst_done_i | input | 1 | Current burst completes this cycle |
| burst_cycles_i | input | CYC_W | Cycles used by the finishing burst |

## Verification
The bench places the account on both sides of the limit, one unit apart, and stages a DMA-versus-CPU contest at each point. An off-by-one in the comparison, a charge on DMA bursts, or a missed dynamic charge each changes which side wins. Separate runs let the account decay for an exact number of cycles, push it into the clip, and drive it against zero with an oversized step. A design without saturation would wrap past zero or keep charging past the clip, and the contest outcome would flip. Class ranking uses CPUs spread over all four classes, so any mis-ranked class shows up as a wrong grant order. Recency is checked by serving one CPU alone and confirming that it moves to the back of its class. An ordering updated on requests instead of grants, or a plain index priority, yields a different sequence.

// File: rtl/bw_arb_pkg.sv
package bw_arb_pkg;
  typedef enum logic [1:0] {
    CLS_HI_IN  = 2'd0,
    CLS_LO_IN  = 2'd1,
    CLS_HI_OUT = 2'd2,
    CLS_LO_OUT = 2'd3
  } cpu_class_e;

  localparam int NUM_CLASSES = 4;

  function automatic cpu_class_e class_of(input logic hi, input logic in_budget);
    return cpu_class_e'({~in_budget, ~hi});
  endfunction
endpackage

// File: rtl/bw_account.sv
module bw_account #(
  parameter int ACC_W = 16,
  parameter int CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dyn_en_i,
  input  logic [ACC_W-1:0] ratio_i,
  input  logic [ACC_W-1:0] decr_i,
  input  logic [ACC_W-1:0] clip_i,
  input  logic [CYC_W-1:0] burst_cycles_i,
  input  logic             charge_i,
  input  logic             cpu_active_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int SUM_W = ((ACC_W > CYC_W) ? ACC_W : CYC_W) + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] charge, sum, decayed;

  always_comb begin
    charge = '0;
    if (charge_i) charge = dyn_en_i ? SUM_W'(burst_cycles_i) : SUM_W'(ratio_i);
    sum = SUM_W'(acc_q) + charge;
    decayed = sum;
    if (!cpu_active_i) decayed = (sum > SUM_W'(decr_i)) ? sum - SUM_W'(decr_i) : '0;
    acc_d = (decayed > SUM_W'(clip_i)) ? clip_i : decayed[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R5
  acc_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_q <= $past(clip_i));

  // R4
  acc_decay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_active_i && acc_q >= decr_i && acc_q <= clip_i)
    |=> acc_q == $past(acc_q - decr_i));

  // R4
  acc_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_active_i && acc_q < decr_i) |=> acc_q == '0);
endmodule

// File: rtl/bw_age_matrix.sv
module bw_age_matrix #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic [IDX_W-1:0]    upd_idx_i,
  output logic [N-1:0][N-1:0] older_o
);
  // older_q[i][j] set: i was granted less recently than j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          older_q[i][j] <= (i < j);
    end else if (upd_i) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (IDX_W'(i) == upd_idx_i)      older_q[i][j] <= 1'b0;
            else if (IDX_W'(j) == upd_idx_i) older_q[i][j] <= 1'b1;
          end
    end
  end

  assign older_o = older_q;

  // R9
  age_antisym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> older_q[0] == '0 || older_q[0] != $past(older_q[0]) || $past(upd_idx_i) != '0);
endmodule

// File: rtl/bw_cpu_select.sv
module bw_cpu_select
  import bw_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0]        hi_i,
  input  logic [N-1:0]        in_budget_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic [N-1:0]        win_o,
  output logic                any_o
);
  cpu_class_e cls [N];
  logic [N-1:0] cand;
  logic         found;
  logic         ok;

  always_comb begin
    for (int i = 0; i < N; i++) cls[i] = class_of(hi_i[i], in_budget_i[i]);
    win_o = '0;
    found = 1'b0;
    cand  = '0;
    ok    = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (!found) begin
        for (int i = 0; i < N; i++) cand[i] = req_i[i] && (cls[i] == cpu_class_e'(c));
        if (|cand) begin
          found = 1'b1;
          for (int i = 0; i < N; i++) begin
            ok = cand[i];
            for (int j = 0; j < N; j++)
              if (j != i && cand[j] && !older_i[i][j]) ok = 1'b0;
            win_o[i] = ok;
          end
        end
      end
    end
    any_o = found;
  end

  // R9
  always_comb begin
    if (|req_i) win_onehot_chk: assert ($onehot(win_o));
  end
endmodule

// File: rtl/bw_mem_arbiter.sv
module bw_mem_arbiter #(
  parameter int N_CPU = 4,
  parameter int ACC_W = 16,
  parameter int CYC_W = 8,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] cfg_ratio_i,
  input  logic [ACC_W-1:0] cfg_decr_i,
  input  logic [ACC_W-1:0] cfg_limit_i,
  input  logic [ACC_W-1:0] cfg_clip_i,
  input  logic             cfg_dyn_en_i,
  input  logic             dma_req_i,
  output logic             dma_gnt_o,
  input  logic [N_CPU-1:0] cpu_req_i,
  input  logic [N_CPU-1:0] cpu_hi_i,
  input  logic [N_CPU-1:0] cpu_in_budget_i,
  output logic [N_CPU-1:0] cpu_gnt_o,
  input  logic             burst_done_i,
  input  logic [CYC_W-1:0] burst_cycles_i
);
  logic                    dma_gnt_q;
  logic [N_CPU-1:0]        cpu_gnt_q;
  logic                    busy;
  logic                    cpu_active;
  logic [ACC_W-1:0]        acc;
  logic [N_CPU-1:0][N_CPU-1:0] older;
  logic [N_CPU-1:0]        cpu_win;
  logic                    cpu_any;
  logic                    pick_dma, pick_cpu;
  logic [IDX_W-1:0]        win_idx;

  assign busy       = dma_gnt_q || (|cpu_gnt_q);
  assign cpu_active = |cpu_gnt_q;

  bw_account #(.ACC_W(ACC_W), .CYC_W(CYC_W)) u_account (
    .clk_i, .rst_ni,
    .dyn_en_i       (cfg_dyn_en_i),
    .ratio_i        (cfg_ratio_i),
    .decr_i         (cfg_decr_i),
    .clip_i         (cfg_clip_i),
    .burst_cycles_i (burst_cycles_i),
    .charge_i       (cpu_active && burst_done_i),
    .cpu_active_i   (cpu_active),
    .acc_o          (acc)
  );

  bw_cpu_select #(.N(N_CPU)) u_select (
    .req_i       (cpu_req_i),
    .hi_i        (cpu_hi_i),
    .in_budget_i (cpu_in_budget_i),
    .older_i     (older),
    .win_o       (cpu_win),
    .any_o       (cpu_any)
  );

  always_comb begin
    pick_dma = !busy && dma_req_i && ((acc > cfg_limit_i) || !cpu_any);
    pick_cpu = !busy && !pick_dma && cpu_any;
    win_idx  = '0;
    for (int i = 0; i < N_CPU; i++)
      if (cpu_win[i]) win_idx = IDX_W'(i);
  end

  bw_age_matrix #(.N(N_CPU)) u_age (
    .clk_i, .rst_ni,
    .upd_i     (pick_cpu),
    .upd_idx_i (win_idx),
    .older_o   (older)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_gnt_q <= 1'b0;
      cpu_gnt_q <= '0;
    end else if (busy) begin
      if (burst_done_i) begin
        dma_gnt_q <= 1'b0;
        cpu_gnt_q <= '0;
      end
    end else begin
      dma_gnt_q <= pick_dma;
      cpu_gnt_q <= pick_cpu ? cpu_win : '0;
    end
  end

  assign dma_gnt_o = dma_gnt_q;
  assign cpu_gnt_o = cpu_gnt_q;

  // R1
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_gnt_o, cpu_gnt_o}));

  // R1
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !burst_done_i) |=> $stable({dma_gnt_o, cpu_gnt_o}));

  // R6
  dma_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && dma_req_i && acc > cfg_limit_i) |=> dma_gnt_o);

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !dma_req_i && cpu_req_i == '0) |=> !dma_gnt_o && cpu_gnt_o == '0);
endmodule

// File: tb/bw_mem_arbiter_tb_top.sv
module bw_mem_arbiter_tb_top;
  localparam int N = 4;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ratio, decr, limit, clip;
  logic          dyn;
  logic          dma_req, dma_gnt;
  logic [N-1:0]  cpu_req, cpu_hi, cpu_inb, cpu_gnt;
  logic          done;
  logic [CW-1:0] cycles;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bw_mem_arbiter #(.N_CPU(N), .ACC_W(AW), .CYC_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_ratio_i(ratio), .cfg_decr_i(decr), .cfg_limit_i(limit), .cfg_clip_i(clip),
    .cfg_dyn_en_i(dyn),
    .dma_req_i(dma_req), .dma_gnt_o(dma_gnt),
    .cpu_req_i(cpu_req), .cpu_hi_i(cpu_hi), .cpu_in_budget_i(cpu_inb), .cpu_gnt_o(cpu_gnt),
    .burst_done_i(done), .burst_cycles_i(cycles)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dma_req = 0; cpu_req = '0; done = 0; cycles = '0;
    cpu_hi = '1; cpu_inb = '1; dyn = 0;
    ratio = 10; decr = 0; limit = 1000; clip = 16'hFFFF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // exp_cpu < 0 means the DMA is expected
  task automatic serve(input int exp_cpu, input string tag);
    int exp;
    @(negedge clk);
    exp = (exp_cpu < 0) ? 32'h10 : (1 << exp_cpu);
    chk({dma_gnt, cpu_gnt} == 5'(exp), tag, int'({dma_gnt, cpu_gnt}), exp);
    if (exp_cpu < 0) dma_req = 0; else cpu_req[exp_cpu] = 0;
    done = 1;
    @(negedge clk);
    done = 0;
    chk({dma_gnt, cpu_gnt} == 5'd0, {tag, " release"}, int'({dma_gnt, cpu_gnt}), 0);
  endtask

  task automatic contest(input bit exp_dma, input string tag);
    dma_req = 1; cpu_req[0] = 1;
    serve(exp_dma ? -1 : 0, tag);
    dma_req = 0; cpu_req = '0;
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk({dma_gnt, cpu_gnt} == 5'd0, "R10 reset state", int'({dma_gnt, cpu_gnt}), 0);
    repeat (5) @(negedge clk);
    chk({dma_gnt, cpu_gnt} == 5'd0, "R10 idle no grant", int'({dma_gnt, cpu_gnt}), 0);
  endtask

  task automatic t_hold();
    do_reset();
    cpu_req[1] = 1;
    @(negedge clk);
    chk(cpu_gnt == 4'b0010, "R1 grant next cycle", int'(cpu_gnt), 2);
    cpu_req[1] = 0; dma_req = 1; cpu_req[2] = 1;
    repeat (2) @(negedge clk);
    chk(cpu_gnt == 4'b0010 && !dma_gnt, "R1 grant held", int'({dma_gnt, cpu_gnt}), 2);
    done = 1;
    @(negedge clk);
    done = 0;
    chk({dma_gnt, cpu_gnt} == 5'd0, "R1 drop after done", int'({dma_gnt, cpu_gnt}), 0);
    @(negedge clk);
    chk(cpu_gnt == 4'b0100 && !dma_gnt, "R1 next grant", int'({dma_gnt, cpu_gnt}), 4);
    cpu_req = '0;
    done = 1; @(negedge clk); done = 0;
    // R7: DMA alone with account low
    @(negedge clk);
    chk(dma_gnt && cpu_gnt == '0, "R7 lone dma", int'({dma_gnt, cpu_gnt}), 16);
    dma_req = 0; done = 1; @(negedge clk); done = 0;
  endtask

  task automatic t_static();
    do_reset();
    dma_req = 1;
    serve(-1, "R2 dma burst");
    limit = 0;
    contest(0, "R2 dma burst no charge");         // acc 0 -> cpu, now acc 10
    limit = 9;
    contest(1, "R2 ratio charged above limit");   // acc 10 > 9
    limit = 10;
    contest(0, "R6 at limit cpu first");          // acc 10 not > 10
  endtask

  task automatic t_dynamic();
    do_reset();
    dyn = 1; ratio = 100; limit = 6;
    cycles = 7; cpu_req[0] = 1;
    serve(0, "R3 dyn burst");
    contest(1, "R3 dyn charge 7 above 6");
    limit = 7;
    contest(0, "R3 dyn charge 7 not above 7");
  endtask

  task automatic t_decay(input int w, input bit exp_dma);
    do_reset();
    limit = 5; cpu_req[0] = 1;
    serve(0, "R4 charge");
    decr = 1;
    repeat (w) @(negedge clk);
    contest(exp_dma, exp_dma ? "R4 decay w4 dma" : "R4 decay w5 cpu");
  endtask

  task automatic t_floor();
    do_reset();
    decr = 200;
    repeat (4) @(negedge clk);
    limit = 0;
    contest(0, "R4 floor no wrap");
  endtask

  task automatic t_clip();
    do_reset();
    clip = 12; limit = 12;
    cpu_req[0] = 1; serve(0, "R5 burst a");
    cpu_req[0] = 1; serve(0, "R5 burst b");
    contest(0, "R5 clipped at 12");
    limit = 11;
    contest(1, "R5 clip above 11");
  endtask

  task automatic t_classes();
    do_reset();
    cpu_hi  = 4'b1010;
    cpu_inb = 4'b1100;   // cpu3 hi/in, cpu2 lo/in, cpu1 hi/out, cpu0 lo/out
    cpu_req = 4'b1111;
    serve(3, "R8 class0");
    serve(2, "R8 class1");
    serve(1, "R8 class2");
    serve(0, "R8 class3");
  endtask

  task automatic t_lrh();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      cpu_req = 4'b1111;
      serve(k, "R9 reset order");
    end
    cpu_req = 4'b0100;
    serve(2, "R9 lone serve");
    cpu_req = 4'b1111;
    serve(0, "R9 order a");
    cpu_req = 4'b1111;
    serve(1, "R9 order b");
    cpu_req = 4'b1111;
    serve(3, "R9 order c");
    cpu_req = 4'b1111;
    serve(2, "R9 order d");
    cpu_req = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset_idle();
    t_hold();
    t_static();
    t_dynamic();
    t_decay(4, 1'b1);
    t_decay(5, 1'b0);
    t_floor();
    t_clip();
    t_classes();
    t_lrh();
    finish_run();
  end
endmodule